// File: doc/BRIEF.md
# Event Counter Bank with Class-Specific Write Rules

This block holds a small set of event counters for performance monitoring. There are two classes of counter: general-purpose counters and fixed-function counters. Each class has its own width parameter. Each counter adds one on every clock in which its event input is high and its enable bit is set. When a counter steps past its all-ones value it wraps to zero and raises a one-cycle overflow flag.

Software reaches every counter, the enable control word and two read-only capability words through a plain register port. The port carries an address, write data, a write strobe, a read strobe, a privilege qualifier, combinational read data and a combinational error flag. There is no streaming data path, so the port uses no valid/ready handshake. An access completes in the cycle its strobe is high and is never stalled.

The two counter classes take writes differently. A general-purpose counter sign-extends bit 31 of an ordinary write, and takes the raw value when the write is privileged. A fixed counter takes the value as written, but it refuses the whole write when any bit above its width is set.

Address map:
- General-purpose counter i sits at address i.
- Fixed counter i sits at 8+i.
- The enable word sits at 16.
- The general-purpose capability word sits at 17.
- The fixed capability word sits at 18.

Top module: `perf_counter_bank`

## Requirements
- R1: While `rst` is high and after it falls, every counter reads zero, every enable bit is clear and both overflow outputs are low.
- R2: A counter adds one on each rising edge where its event bit and its enable bit are both high. With its enable bit clear, it holds its value.
- R3: A counter holding all ones that counts wraps to zero. Its bit in `gp_ovf`/`fx_ovf` is high for exactly the cycle after that edge.
- R4: A write to a general-purpose counter with `priv` low loads `wdata[31:0]`. Every counter bit above 31 is filled with `wdata[31]`, and `wdata[63:32]` is ignored.
- R5: A write to a general-purpose counter with `priv` high loads `wdata` truncated to the counter width, with no sign extension.
- R6: A write to a fixed counter whose bits at and above `FX_W` are all zero loads `wdata` unchanged and does not raise `err`.
- R7: A write to a fixed counter with any bit at or above `FX_W` set raises `err` in that cycle and leaves the counter unchanged.
- R8: A counter written in a cycle where it would also count loads the written value. That cycle's event is dropped and no overflow is flagged.
- R9: A counter read returns the counter in the low bits, with zeros above its width. Address 17 reads `GP_W` in bits 23:16, and address 18 reads `FX_W` in bits 12:5. All other bits of both words read zero.
- R10: A read or write to an unmapped address (2–7, 10–15 and 19–31 by default) reads zero and raises `err`. A write to either capability word raises `err` and changes nothing.
- R11: The enable word at address 16 holds general-purpose enables in bits `NUM_GP-1:0` and fixed enables in the bits directly above. It can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 5 | Register address |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| priv | input | 1 | Qualifies a write as privileged |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| err | output | 1 | Error response for the current access, combinational |
| gp_evt | input | NUM_GP | Event inputs for the general-purpose counters |
| fx_evt | input | NUM_FX | Event inputs for the fixed counters |
| gp_ovf | output | NUM_GP | One-cycle wrap flags for the general-purpose counters |
| fx_ovf | output | NUM_FX | One-cycle wrap flags for the fixed counters |

## Verification
A software load and a counting event can hit the same counter on the same edge. The bench provokes this by holding a counter's event high while writing it, both for a mid-range value and for all ones, which would otherwise wrap. A behavioural model predicts the result on every clock, and a later read plus the overflow outputs are judged against it: the written value must appear untouched and no overflow may show. A refused fixed-counter write paired with an event is also driven, and there the event must still count.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned IDX_W  = 3;

  localparam logic [ADDR_W-1:0] A_FX_BASE = 5'd8;
  localparam logic [ADDR_W-1:0] A_CTRL    = 5'd16;
  localparam logic [ADDR_W-1:0] A_CAP_GP  = 5'd17;
  localparam logic [ADDR_W-1:0] A_CAP_FX  = 5'd18;

  typedef enum logic [2:0] {
    K_NONE,
    K_GP,
    K_FX,
    K_CTRL,
    K_CAPGP,
    K_CAPFX
  } acc_kind_e;
endpackage

// File: rtl/pcb_decode.sv
module pcb_decode
  import pcb_pkg::*;
#(
  parameter int unsigned NUM_GP = 2,
  parameter int unsigned NUM_FX = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    idx  = addr[IDX_W-1:0];
    kind = K_NONE;
    if (addr[ADDR_W-1:IDX_W] == 2'b00) begin
      if (32'(addr[IDX_W-1:0]) < NUM_GP) kind = K_GP;
    end else if (addr[ADDR_W-1:IDX_W] == A_FX_BASE[ADDR_W-1:IDX_W]) begin
      if (32'(addr[IDX_W-1:0]) < NUM_FX) kind = K_FX;
    end else if (addr == A_CTRL) begin
      kind = K_CTRL;
    end else if (addr == A_CAP_GP) begin
      kind = K_CAPGP;
    end else if (addr == A_CAP_FX) begin
      kind = K_CAPFX;
    end
  end
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (ld) begin
      // a load wins over a same-cycle event
      cnt <= ld_val;
      ovf <= 1'b0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
      ovf <= &cnt;
    end else begin
      ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int unsigned NUM_GP = 2,
  parameter int unsigned NUM_FX = 2,
  parameter int unsigned GP_W   = 40,
  parameter int unsigned FX_W   = 48,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              priv,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  input  logic [NUM_GP-1:0] gp_evt,
  input  logic [NUM_FX-1:0] fx_evt,
  output logic [NUM_GP-1:0] gp_ovf,
  output logic [NUM_FX-1:0] fx_ovf
);
  localparam int unsigned EN_W = NUM_GP + NUM_FX;
  localparam logic [DATA_W-1:0] FX_KEEP = {{(DATA_W-FX_W){1'b0}}, {FX_W{1'b1}}};

  acc_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic [EN_W-1:0]  en_q;
  logic [GP_W-1:0]  gp_cnt [NUM_GP];
  logic [FX_W-1:0]  fx_cnt [NUM_FX];
  logic [DATA_W-1:0] sx_data;
  logic [GP_W-1:0]  gp_ldval;
  logic             fx_rsvd;

  pcb_decode #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_dec (
    .addr (addr),
    .kind (kind),
    .idx  (idx)
  );

  assign sx_data  = {{(DATA_W-32){wdata[31]}}, wdata[31:0]};
  assign gp_ldval = priv ? wdata[GP_W-1:0] : sx_data[GP_W-1:0];
  assign fx_rsvd  = |(wdata & ~FX_KEEP);

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    logic ld;
    assign ld = wr_en && (kind == K_GP) && (idx == IDX_W'(g));
    pcb_counter #(.W(GP_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .ld     (ld),
      .ld_val (gp_ldval),
      .inc    (gp_evt[g] && en_q[g]),
      .cnt    (gp_cnt[g]),
      .ovf    (gp_ovf[g])
    );
  end

  for (genvar f = 0; f < NUM_FX; f++) begin : g_fx
    logic ld;
    assign ld = wr_en && (kind == K_FX) && (idx == IDX_W'(f)) && !fx_rsvd;
    pcb_counter #(.W(FX_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .ld     (ld),
      .ld_val (wdata[FX_W-1:0]),
      .inc    (fx_evt[f] && en_q[NUM_GP+f]),
      .cnt    (fx_cnt[f]),
      .ovf    (fx_ovf[f])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (wr_en && kind == K_CTRL) en_q <= wdata[EN_W-1:0];
  end

  always_comb begin
    rdata = '0;
    unique case (kind)
      K_GP: begin
        for (int i = 0; i < NUM_GP; i++)
          if (idx == IDX_W'(i)) rdata = DATA_W'(gp_cnt[i]);
      end
      K_FX: begin
        for (int i = 0; i < NUM_FX; i++)
          if (idx == IDX_W'(i)) rdata = DATA_W'(fx_cnt[i]);
      end
      K_CTRL:  rdata = DATA_W'(en_q);
      K_CAPGP: rdata[23:16] = 8'(GP_W);
      K_CAPFX: rdata[12:5]  = 8'(FX_W);
      default: rdata = '0;
    endcase
  end

  assign err = ((wr_en || rd_en) && kind == K_NONE)
            || (wr_en && (kind == K_CAPGP || kind == K_CAPFX))
            || (wr_en && kind == K_FX && fx_rsvd);
endmodule

// File: rtl/pcb_chk.sv
module pcb_chk #(
  parameter int unsigned NUM_GP = 2,
  parameter int unsigned NUM_FX = 2,
  parameter int unsigned GP_W   = 40,
  parameter int unsigned FX_W   = 48,
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic              err,
  input logic [NUM_GP-1:0] gp_ovf,
  input logic [NUM_FX-1:0] fx_ovf
);
  logic [NUM_GP-1:0] gp_hit;
  logic              unmapped;

  always_comb begin
    for (int i = 0; i < NUM_GP; i++) gp_hit[i] = (addr == 5'(i));
  end

  assign unmapped = !((32'(addr) < NUM_GP) ||
                      (addr >= 5'd8 && 32'(addr) < 8 + NUM_FX) ||
                      (addr >= 5'd16 && addr <= 5'd18));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (gp_ovf == '0 && fx_ovf == '0));

  // R3
  ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|gp_ovf || |fx_ovf) |=> ((gp_ovf & $past(gp_ovf)) == '0 && (fx_ovf & $past(fx_ovf)) == '0));

  // R8
  load_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && |gp_hit) |=> ((gp_ovf & $past(gp_hit)) == '0));

  // R9
  cap_gp_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == 5'd17) |-> (rdata == (DATA_W'(GP_W) << 16) && !err));

  // R10
  unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && unmapped) |-> (err && rdata == '0));
endmodule

bind perf_counter_bank pcb_chk #(
  .NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W), .FX_W(FX_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .err(err), .gp_ovf(gp_ovf), .fx_ovf(fx_ovf)
);

// File: tb/tb_perf_counter_bank.sv
module tb_perf_counter_bank;
  localparam int NG = 2, NF = 2, GW = 40, FW = 48;
  localparam logic [63:0] GM = (64'd1 << GW) - 1;
  localparam logic [63:0] FM = (64'd1 << FW) - 1;

  logic clk = 0, rst = 1;
  logic [4:0] addr = '0;
  logic [63:0] wdata = '0;
  logic wr_en = 0, rd_en = 0, priv = 0;
  logic [63:0] rdata;
  logic err;
  logic [NG-1:0] gp_evt = '0, gp_ovf;
  logic [NF-1:0] fx_evt = '0, fx_ovf;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [63:0] m_gp [NG];
  logic [63:0] m_fx [NF];
  logic [3:0]  m_en;
  logic [NG-1:0] m_go;
  logic [NF-1:0] m_fo;

  always #5 clk = ~clk;

  perf_counter_bank dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .priv(priv), .rdata(rdata), .err(err),
    .gp_evt(gp_evt), .fx_evt(fx_evt), .gp_ovf(gp_ovf), .fx_ovf(fx_ovf)
  );

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] m_read(logic [4:0] a);
    if (a < NG) return m_gp[a];
    if (a >= 8 && a < 8 + NF) return m_fx[a-8];
    if (a == 16) return 64'(m_en);
    if (a == 17) return 64'(GW) << 16;
    if (a == 18) return 64'(FW) << 5;
    return '0;
  endfunction

  function automatic bit m_err(logic [4:0] a, logic [63:0] d, bit w, bit r);
    bit mapped = (a < NG) || (a >= 8 && a < 8 + NF) || (a >= 16 && a <= 18);
    if ((w || r) && !mapped) return 1;
    if (w && (a == 17 || a == 18)) return 1;
    if (w && a >= 8 && a < 8 + NF && (d & ~FM) != 0) return 1;
    return 0;
  endfunction

  // one clock: drive, compare combinational outputs, advance model, compare flags
  task automatic step(string tag, logic [4:0] a, logic [63:0] d, bit w, bit r,
                      bit p, logic [NG-1:0] ge, logic [NF-1:0] fe);
    addr = a; wdata = d; wr_en = w; rd_en = r; priv = p; gp_evt = ge; fx_evt = fe;
    #1;
    if (w || r) begin
      cmp(tag, "rdata", rdata, m_read(a));
      cmp(tag, "err", 64'(err), 64'(m_err(a, d, w, r)));
    end
    @(posedge clk);
    for (int i = 0; i < NG; i++) begin
      m_go[i] = 0;
      if (w && a == 5'(i))
        m_gp[i] = p ? (d & GM) : ({{32{d[31]}}, d[31:0]} & GM);
      else if (ge[i] && m_en[i]) begin
        m_go[i] = (m_gp[i] == GM);
        m_gp[i] = (m_gp[i] + 1) & GM;
      end
    end
    for (int i = 0; i < NF; i++) begin
      m_fo[i] = 0;
      if (w && a == 5'(8 + i) && (d & ~FM) == 0)
        m_fx[i] = d;
      else if (fe[i] && m_en[NG+i]) begin
        m_fo[i] = (m_fx[i] == FM);
        m_fx[i] = (m_fx[i] + 1) & FM;
      end
    end
    if (w && a == 16) m_en = d[3:0];
    @(negedge clk);
    #1;
    cmp(tag, "gp_ovf", 64'(gp_ovf), 64'(m_go));
    cmp(tag, "fx_ovf", 64'(fx_ovf), 64'(m_fo));
  endtask

  task automatic rd(string tag, logic [4:0] a);
    step(tag, a, '0, 0, 1, 0, '0, '0);
  endtask

  task automatic wr(string tag, logic [4:0] a, logic [63:0] d, bit p);
    step(tag, a, d, 1, 0, p, '0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NG; i++) m_gp[i] = '0;
    for (int i = 0; i < NF; i++) m_fx[i] = '0;
    m_en = '0; m_go = '0; m_fo = '0;
    repeat (3) @(negedge clk);
    #1;
    cmp("R1", "gp_ovf in reset", 64'(gp_ovf), 0);
    rst = 0;

    // R1 reset state, R9 capability words, R11 enable word
    for (int a = 0; a < NG; a++) rd("R1", 5'(a));
    for (int a = 0; a < NF; a++) rd("R1", 5'(8 + a));
    rd("R11", 5'd16);
    rd("R9", 5'd17);
    rd("R9", 5'd18);
    // R10 unmapped reads
    rd("R10", 5'd3);
    rd("R10", 5'd11);
    rd("R10", 5'd25);

    // R2 disabled counters hold
    repeat (3) step("R2", 5'd0, '0, 0, 0, 0, 2'b11, 2'b11);
    rd("R2", 5'd0);
    rd("R2", 5'd9);

    // R11 enable bits and R2 counting
    wr("R11", 5'd16, 64'hFFFF_FFFF_FFFF_FFF5, 0);
    rd("R11", 5'd16);
    step("R2", 5'd0, '0, 0, 0, 0, 2'b11, 2'b11);
    step("R2", 5'd0, '0, 0, 0, 0, 2'b01, 2'b10);
    step("R2", 5'd0, '0, 0, 0, 0, 2'b11, 2'b01);
    for (int a = 0; a < NG; a++) rd("R2", 5'(a));
    for (int a = 0; a < NF; a++) rd("R2", 5'(8 + a));
    wr("R11", 5'd16, 64'hF, 0);

    // R4 ordinary writes sign-extend bit 31
    wr("R4", 5'd0, 64'hDEAD_0000_8000_0001, 0);
    rd("R4", 5'd0);
    wr("R4", 5'd1, 64'h0000_00AB_7FFF_FFFF, 0);
    rd("R4", 5'd1);

    // R5 privileged writes load raw, truncated
    wr("R5", 5'd0, 64'h0000_00AB_1234_5678, 1);
    rd("R5", 5'd0);
    wr("R5", 5'd1, 64'hFFFF_AB12_3456_789A, 1);
    rd("R5", 5'd1);

    // R6 fixed write within width
    wr("R6", 5'd8, 64'h0000_8765_4321_0000, 0);
    rd("R6", 5'd8);
    wr("R6", 5'd9, 64'h0000_0000_0000_0042, 1);
    rd("R6", 5'd9);

    // R7 reserved bits refused, counter untouched; event still counts
    wr("R7", 5'd8, 64'h0001_0000_0000_0005, 0);
    rd("R7", 5'd8);
    step("R7", 5'd9, 64'h8000_0000_0000_0000, 1, 0, 1, 2'b00, 2'b10);
    rd("R7", 5'd9);

    // R3 wrap with overflow pulse
    wr("R3", 5'd0, 64'h0000_0000_FFFF_FFFF, 0);
    step("R3", 5'd0, '0, 0, 0, 0, 2'b01, 2'b00);
    step("R3", 5'd0, '0, 0, 0, 0, 2'b01, 2'b00);
    rd("R3", 5'd0);
    wr("R3", 5'd9, FM, 0);
    step("R3", 5'd0, '0, 0, 0, 0, 2'b00, 2'b10);
    rd("R3", 5'd9);

    // R8 write wins over same-cycle event
    step("R8", 5'd1, 64'h5, 1, 0, 1, 2'b10, 2'b00);
    rd("R8", 5'd1);
    wr("R8", 5'd1, 64'hFFFF_FFFF, 0);
    step("R8", 5'd1, 64'hFFFF_FFFF, 1, 0, 0, 2'b10, 2'b00);
    rd("R8", 5'd1);
    step("R8", 5'd8, FM, 1, 0, 0, 2'b00, 2'b01);
    step("R8", 5'd8, 64'h7, 1, 0, 0, 2'b00, 2'b01);
    rd("R8", 5'd8);

    // R10 writes to capability and unmapped addresses
    wr("R10", 5'd17, 64'hFFFF, 0);
    rd("R10", 5'd17);
    wr("R10", 5'd18, 64'hFFFF, 0);
    rd("R10", 5'd18);
    wr("R10", 5'd30, 64'h1234, 0);
    rd("R10", 5'd30);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule